// File: doc/BRIEF.md
# Context-Switched Two-Stage Address Translator

This block translates a 21-bit virtual byte address into a 21-bit physical byte address in two table lookups. A 4-bit context value is held inside the block and selects one of sixteen address spaces. The first table is the segment map. It is indexed by the context together with the segment field of the address, and it returns a page-group pointer. The second table is the page map. It is indexed by that pointer together with the page-within-segment field, and it returns a physical page number, a valid flag and two write-permission flags. A page is 2 KB and a segment is 32 KB, so each segment holds 16 pages. Each context can reach 1024 pages (2 MB), and the page map can reach 2 MB of physical memory.

Because all sixteen address spaces stay resident in the maps, a task switch only needs one write to the context value. Software loads the context value and both maps through a configuration port. That port accepts a write only when it is flagged as coming from supervisor state. Translation requests enter one per cycle on a request port. Two cycles later a result strobe returns the physical address, or a fault if the page is unmapped or the write is not permitted.

Top module: `ctx_xlate`

## Requirements
- R1: While reset is asserted and after it is released, with no request pending, rsp_valid, rsp_fault and rsp_paddr are all 0, and the context value is 0.
- R2: A request sampled on a clock edge produces rsp_valid exactly two edges later. For a non-faulting result, rsp_paddr equals the page map's physical page number in bits 20:11, followed by the request's offset bits 10:0 unchanged.
- R3: The virtual address splits into a segment field (bits 20:15), a page-within-segment field (bits 14:11) and an offset (bits 10:0). The segment map is indexed by {context, segment}. The page map is indexed by {group pointer, page-within-segment}.
- R4: The context value selects which of 16 segment-map regions is used. A request uses the context in force on the edge where the request is sampled, and a context write on that same edge affects only later requests.
- R5: A configuration write with cfg_sup = 0 leaves the context value, the segment map and the page map unchanged.
- R6: The context used for translation does not depend on req_sup. Only the write-permission check uses req_sup.
- R7: A page-map entry whose valid bit (bit 12) is 0 gives rsp_fault = 1 and rsp_paddr = 0, for both reads and writes.
- R8: A write request needs the user write bit (bit 11) when req_sup = 0, and the supervisor write bit (bit 10) when req_sup = 1. Otherwise it faults with rsp_paddr = 0. A read to a valid entry never faults.
- R9: The configuration port selects its target with cfg_sel: 0 loads the context from cfg_data[3:0]; 1 loads segment-map entry cfg_addr with cfg_data[5:0]; 2 loads page-map entry cfg_addr with cfg_data[12:0] (valid, user write, supervisor write, page number in bits 9:0); 3 has no effect.
- R10: Requests may arrive on every cycle, and each one yields its own result in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sup | input | 1 | Configuration write comes from supervisor state |
| cfg_sel | input | 2 | Configuration target: context, segment map, page map, none |
| cfg_addr | input | 10 | Map entry index for configuration writes |
| cfg_data | input | 13 | Configuration write data |
| req_valid | input | 1 | Translation request strobe |
| req_sup | input | 1 | Requester is in supervisor state |
| req_write | input | 1 | Request is a write access |
| req_vaddr | input | 21 | Virtual byte address |
| rsp_valid | output | 1 | Translation result strobe |
| rsp_fault | output | 1 | Access unmapped or write not permitted |
| rsp_paddr | output | 21 | Physical byte address, zero on fault |

## Verification
The maps and the context register are not visible at the ports, so a wrong internal value can only be seen in a translation. If the context is wrong, or a protected write slipped through, the next request that touches that context or entry returns a different page number or a different fault flag. That error appears two cycles after the request. The bench therefore follows every ignored or ordered configuration write with requests aimed at the exact entries involved. It then compares every output on every cycle against a behavioural model, so a divergence is reported in the cycle where it first reaches rsp_paddr or rsp_fault.

// File: rtl/ctx_xlate.sv
module ctx_xlate #(
  parameter int CTX_W = 4,
  parameter int SEG_W = 6,
  parameter int PIS_W = 4,
  parameter int OFF_W = 11,
  parameter int GRP_W = 6,
  parameter int PPN_W = 10,
  localparam int VA_W   = SEG_W + PIS_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int SM_AW  = CTX_W + SEG_W,
  localparam int PM_AW  = GRP_W + PIS_W,
  localparam int PTE_W  = PPN_W + 3,
  localparam int CFG_AW = (SM_AW > PM_AW) ? SM_AW : PM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sup,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [PTE_W-1:0]  cfg_data,
  input  logic              req_valid,
  input  logic              req_sup,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [PA_W-1:0]   rsp_paddr
);

  localparam int PTE_V  = PTE_W - 1;
  localparam int PTE_UW = PTE_W - 2;
  localparam int PTE_SW = PTE_W - 3;

  logic [CTX_W-1:0] ctx_q;
  logic [GRP_W-1:0] seg_mem [2**SM_AW];
  logic [PTE_W-1:0] pte_mem [2**PM_AW];

  wire cfg_ok = cfg_we & cfg_sup;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         ctx_q <= '0;
    else if (cfg_ok && cfg_sel == 2'd0) ctx_q <= cfg_data[CTX_W-1:0];

  always_ff @(posedge clk) begin
    if (cfg_ok && cfg_sel == 2'd1) seg_mem[cfg_addr[SM_AW-1:0]] <= cfg_data[GRP_W-1:0];
    if (cfg_ok && cfg_sel == 2'd2) pte_mem[cfg_addr[PM_AW-1:0]] <= cfg_data;
  end

  wire [SEG_W-1:0] va_seg = req_vaddr[VA_W-1 -: SEG_W];
  wire [PIS_W-1:0] va_pis = req_vaddr[OFF_W +: PIS_W];
  wire [OFF_W-1:0] va_off = req_vaddr[OFF_W-1:0];

  logic             s1_v, s1_sup, s1_wr;
  logic [GRP_W-1:0] s1_grp;
  logic [PIS_W-1:0] s1_pis;
  logic [OFF_W-1:0] s1_off;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s1_v <= 1'b0;
    else        s1_v <= req_valid;

  always_ff @(posedge clk)
    if (req_valid) begin
      s1_grp <= seg_mem[{ctx_q, va_seg}];
      s1_pis <= va_pis;
      s1_off <= va_off;
      s1_sup <= req_sup;
      s1_wr  <= req_write;
    end

  wire [PTE_W-1:0] pte    = pte_mem[{s1_grp, s1_pis}];
  wire             wr_ok  = s1_sup ? pte[PTE_SW] : pte[PTE_UW];
  wire             fault  = ~pte[PTE_V] | (s1_wr & ~wr_ok);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= s1_v;
      rsp_fault <= s1_v & fault;
      rsp_paddr <= (s1_v & ~fault) ? {pte[PPN_W-1:0], s1_off} : '0;
    end

endmodule

// File: rtl/ctx_xlate_chk.sv
module ctx_xlate_chk #(
  parameter int CTX_W = 4,
  parameter int OFF_W = 11,
  parameter int VA_W  = 21,
  parameter int PA_W  = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_sup,
  input logic             req_valid,
  input logic [VA_W-1:0]  req_vaddr,
  input logic [CTX_W-1:0] ctx_q,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [PA_W-1:0]  rsp_paddr
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ##1 !rsp_valid);

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0], 2)));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && rsp_paddr == '0));

  p_user_cfg_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sup) |=> $stable(ctx_q));

endmodule

bind ctx_xlate ctx_xlate_chk #(
  .CTX_W(CTX_W), .OFF_W(OFF_W), .VA_W(VA_W), .PA_W(PA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sup(cfg_sup),
  .req_valid(req_valid), .req_vaddr(req_vaddr), .ctx_q(ctx_q),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/ctx_xlate_bench.sv
`timescale 1ns/1ps
module ctx_xlate_bench;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, cfg_sup = 0;
  logic [1:0]  cfg_sel = 0;
  logic [9:0]  cfg_addr = 0;
  logic [12:0] cfg_data = 0;
  logic        req_valid = 0, req_sup = 0, req_write = 0;
  logic [20:0] req_vaddr = 0;
  logic        rsp_valid, rsp_fault;
  logic [20:0] rsp_paddr;

  ctx_xlate u_ctx_xlate (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  int seg_m [1024];
  int pte_m [1024];
  int m_ctx, m1_grp, m1_pis, m1_off, e_pa;
  bit m1_v, m1_sup, m1_wr, e_v, e_f;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctx = 0; m1_v = 0; e_v = 0; e_f = 0; e_pa = 0;
    end else begin
      int pte; bit ok, flt;
      pte = pte_m[m1_grp*16 + m1_pis];
      ok  = m1_sup ? pte[10] : pte[11];
      flt = !pte[12] || (m1_wr && !ok);
      e_v  = m1_v;
      e_f  = m1_v && flt;
      e_pa = (m1_v && !flt) ? (((pte & 1023) << 11) | m1_off) : 0;
      m1_v = req_valid;
      if (req_valid) begin
        m1_grp = seg_m[m_ctx*64 + int'(req_vaddr >> 15)];
        m1_pis = int'(req_vaddr >> 11) & 15;
        m1_off = int'(req_vaddr) & 2047;
        m1_sup = req_sup;
        m1_wr  = req_write;
      end
      if (cfg_we && cfg_sup)
        case (cfg_sel)
          2'd0: m_ctx = int'(cfg_data) & 15;
          2'd1: seg_m[cfg_addr] = int'(cfg_data) & 63;
          2'd2: pte_m[cfg_addr] = int'(cfg_data);
          default: ;
        endcase
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("rsp_valid", int'(rsp_valid), int'(e_v));
    chk("rsp_fault", int'(rsp_fault), int'(e_f));
    chk("rsp_paddr", int'(rsp_paddr), e_pa);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cfg(int sel, int addr, int data, bit sup);
    @(negedge clk);
    req_valid = 0;
    cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 10'(addr); cfg_data = 13'(data); cfg_sup = sup;
  endtask

  task automatic req(int va, bit wr, bit sup);
    @(negedge clk);
    cfg_we = 0;
    req_valid = 1; req_vaddr = 21'(va); req_write = wr; req_sup = sup;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
    end
  endtask

  initial begin
    phase = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);

    phase = "R9";
    for (int i = 0; i < 1024; i++) cfg(1, i, (i*7 + 3) % 64, 1);
    for (int j = 0; j < 1024; j++)
      cfg(2, j, ((j % 5 != 0) << 12) | ((j % 3 == 0) << 11) | ((j % 2 == 0) << 10) | ((j*13) % 1024), 1);
    cfg(3, 5, 13'h1fff, 1);
    idle(1);

    phase = "R3";
    for (int k = 0; k < 200; k++) req(int'($urandom) & 21'h1fffff, 0, k[0]);
    idle(3);

    phase = "R4";
    for (int c = 0; c < 16; c++) begin
      cfg(0, 0, c, 1);
      for (int k = 0; k < 20; k++) req(int'($urandom) & 21'h1fffff, 0, 1);
    end
    cfg(0, 0, 2, 1);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 0; cfg_data = 13'd7; cfg_sup = 1;
    req_valid = 1; req_vaddr = 21'h0a5a5; req_write = 0; req_sup = 0;
    req(21'h0a5a5, 0, 0);
    idle(3);

    phase = "R5";
    cfg(0, 0, 3, 1);
    cfg(0, 0, 9, 0);
    req(21'h12345, 0, 0);
    cfg(1, 3*64 + 4, 60, 0);
    req(21'h20000 | 21'h1234, 0, 1);
    cfg(2, 1, 0, 0);
    cfg(1, 3*64, 0, 1);
    req(21'h00801, 0, 0);
    idle(3);

    phase = "R6";
    cfg(0, 0, 11, 1);
    for (int k = 0; k < 60; k++) req(int'($urandom) & 21'h1fffff, 0, k[1]);
    idle(3);

    phase = "R8";
    for (int k = 0; k < 300; k++) req(int'($urandom) & 21'h1fffff, k[0] | k[2], k[1]);
    idle(3);

    phase = "R7";
    cfg(2, 0, 13'h0fff, 1);
    cfg(1, 11*64, 0, 1);
    req(21'h00123, 0, 1);
    req(21'h00456, 1, 1);
    idle(3);

    phase = "R10";
    for (int c = 0; c < 4; c++) begin
      cfg(0, 0, c*4, 1);
      for (int k = 0; k < 50; k++) req(int'($urandom) & 21'h1fffff, k[0], k[1]);
    end
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule